// File: doc/BRIEF.md
# ATA PIO Sector Transfer Controller

This block connects a simple host request port to an 8-bit CompactFlash/ATA task-file bus running in PIO mode. The host hands over a direction, a 28-bit logical block address and a sector count. The controller then loads the task-file registers and writes the command. Before every sector it polls the device status until the device is ready to move data. It then moves each sector byte by byte with read or write strobes on the data register.

Sector data passes to and from the host over two valid/ready byte streams. On the read stream the controller holds `rd_valid` and `rd_data` steady until `rd_ready` is seen. It starts the next data strobe only once the previous byte has been taken. On the write stream a byte transfers on a cycle where both `wr_valid` and `wr_ready` are high. The controller raises `wr_ready` only when it can start a strobe at once, so a host that withholds `wr_valid` simply pauses the bus. Control and status stay as plain pins: a request is taken when `req_valid` and `req_ready` are both high, and the outcome is reported by a one-cycle `xfer_done` pulse with a 3-bit code.

Every bus access uses the same timing. Address and chip selects are set up for `SETUP_CYC` cycles. The strobe is then low for `STROBE_CYC` cycles, and address and chip selects are held for `HOLD_CYC` cycles after it rises. Status polling is bounded by `TIMEOUT_CYC` clock cycles per wait, which corresponds to one second at the nominal clock.

Top module: `pio_sector_xfer`

## Requirements
- R1: After reset, both strobes and both chip selects are high, `ata_doe` is low, `req_ready` is high, and `xfer_done` and `rd_valid` are low.
- R2: A request with `req_count` of zero completes with status code 3 (parameter error) and makes no bus access.
- R3: A request while `card_ready` is low completes with status code 4 (not ready) and makes no bus access.
- R4: An accepted request first writes six task-file registers in this order: address 2 gets the count, address 3 gets LBA[7:0], address 4 gets LBA[15:8], address 5 gets LBA[23:16], address 6 gets {4'hE, LBA[27:24]}, and address 7 gets the command (0x20 read, 0x30 write). All task-file accesses use `ata_cs0_n`=0 and `ata_cs1_n`=1.
- R5: Each bus access holds address and chip select for exactly `SETUP_CYC` cycles before the strobe falls and keeps the strobe low for exactly `STROBE_CYC` cycles. It keeps address and chip select for exactly `HOLD_CYC` cycles after the rise, and never lowers both strobes together.
- R6: Before each sector the controller reads status (address 7) repeatedly until bit 7 (busy) is 0 and bit 3 (data request) is 1.
- R7: If a status wait lasts longer than `TIMEOUT_CYC` cycles, the transfer ends with status code 2 (timeout).
- R8: On a read, each sector's `SECTOR_BYTES` bytes are read from address 0 and delivered in order on the read stream. `rd_valid`/`rd_data` stay stable until taken, and no data strobe starts while a byte is waiting.
- R9: On a write, each byte taken from the write stream is written once, in order, to address 0. `ata_doe` is high only during write accesses and is low once a sector ends.
- R10: After the last write sector, status is polled until bit 7 is 0. If bit 0 (error) is then set, the transfer ends with status code 1 (device error).
- R11: A successful transfer ends with a read of the alternate status register (address 6, `ata_cs0_n`=1, `ata_cs1_n`=0), then a read of status (address 7), and then status code 0 (ok).
- R12: A count of N moves exactly N sectors, with one ready wait before each.
- R13: `req_ready` is low from acceptance until completion, and `xfer_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_ready | input | 1 | Card is present and initialized |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken |
| req_write | input | 1 | 1 = write sectors, 0 = read sectors |
| req_lba | input | 28 | Starting logical block address |
| req_count | input | 8 | Number of sectors (1..255) |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_status | output | 3 | 0 ok, 1 device error, 2 timeout, 3 parameter error, 4 not ready |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Controller takes the write byte |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Host takes the read byte |
| ata_addr | output | 3 | Task-file register address |
| ata_cs0_n | output | 1 | Chip select for task-file registers |
| ata_cs1_n | output | 1 | Chip select for control/alternate status |
| ata_iord_n | output | 1 | Read strobe |
| ata_iowr_n | output | 1 | Write strobe |
| ata_dout | output | 8 | Data driven to the device |
| ata_doe | output | 1 | Output enable for `ata_dout` |
| ata_din | input | 8 | Data from the device |

## Verification
The assertions assume that the device keeps `ata_din` stable while a read strobe is low. They also assume the host holds `rd_ready` and the write stream steady between clock edges. The bench device model changes its status and data values only after a strobe has risen. All host-side signals change on the falling clock edge. A request is presented only while `req_ready` is high, and the write source never offers more bytes than the request covers, so the controller never sees stream activity outside a transfer.

// File: rtl/piox_pkg.sv
package piox_pkg;

  typedef enum logic [2:0] {
    XS_OK      = 3'd0,
    XS_DEVERR  = 3'd1,
    XS_TIMEOUT = 3'd2,
    XS_PARAM   = 3'd3,
    XS_NOTRDY  = 3'd4
  } xfer_stat_e;

  localparam logic [7:0] CMD_RD_SECT = 8'h20;
  localparam logic [7:0] CMD_WR_SECT = 8'h30;

  localparam int BIT_BSY = 7;
  localparam int BIT_DRQ = 3;
  localparam int BIT_ERR = 0;

  localparam logic [2:0] RA_DATA = 3'd0;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_ALT  = 3'd6;
  localparam logic [2:0] RA_STAT = 3'd7;

  typedef struct packed {
    logic       wr;
    logic       alt;
    logic [2:0] addr;
    logic [7:0] wdata;
  } bus_op_t;

endpackage

// File: rtl/piox_timer.sv
module piox_timer #(
  parameter int TIMEOUT_CYC = 125_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(TIMEOUT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R7: once the limit is reached it stays reached while the wait lasts
  assert_timer_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && expired) |=> (expired || !run));

endmodule

// File: rtl/piox_bus_engine.sv
module piox_bus_engine
  import piox_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 4,
  parameter int HOLD_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  bus_op_t    op,
  output logic       done,
  output logic [7:0] rdata,
  output logic [2:0] addr,
  output logic       cs0_n,
  output logic       cs1_n,
  output logic       iord_n,
  output logic       iowr_n,
  output logic [7:0] dout,
  output logic       doe,
  input  logic [7:0] din
);
  localparam int MAX_SW = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAXC   = (MAX_SW > HOLD_CYC) ? MAX_SW : HOLD_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_STROBE, E_HOLD} est_e;

  est_e          st;
  logic [CW-1:0] cnt;
  bus_op_t       op_q;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= E_IDLE;
      cnt   <= '0;
      op_q  <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        E_IDLE: if (start) begin
          op_q <= op;
          st   <= E_SETUP;
          cnt  <= CW'(SETUP_CYC - 1);
        end
        E_SETUP: if (cnt == '0) begin
          st  <= E_STROBE;
          cnt <= CW'(STROBE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        E_STROBE: if (cnt == '0) begin
          rdata <= din;
          st    <= E_HOLD;
          cnt   <= CW'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        E_HOLD: if (cnt == '0) begin
          st   <= E_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= E_IDLE;
      endcase
    end
  end

  assign active = (st != E_IDLE);
  assign addr   = op_q.addr;
  assign dout   = op_q.wdata;
  assign cs0_n  = !(active && !op_q.alt);
  assign cs1_n  = !(active && op_q.alt);
  assign iord_n = !((st == E_STROBE) && !op_q.wr);
  assign iowr_n = !((st == E_STROBE) && op_q.wr);
  assign doe    = active && op_q.wr;

  // checker: count strobe-low cycles independently of the state counter
  logic [CW-1:0] chk_low;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                chk_low <= '0;
    else if (!iord_n || !iowr_n) chk_low <= chk_low + 1'b1;
    else                       chk_low <= '0;
  end

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iord_n && iowr_n) |-> (chk_low == CW'(STROBE_CYC)));

  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

endmodule

// File: rtl/piox_seq.sv
module piox_seq
  import piox_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        card_ready,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [27:0] req_lba,
  input  logic [7:0]  req_count,
  output logic        xfer_done,
  output logic [2:0]  xfer_status,
  input  logic [7:0]  wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic        eng_start,
  output bus_op_t     eng_op,
  input  logic        eng_done,
  input  logic [7:0]  eng_rdata,
  output logic        tmr_run,
  input  logic        tmr_expired
);
  localparam int BW = $clog2(SECTOR_BYTES);
  localparam logic [BW-1:0] LAST_BYTE = BW'(SECTOR_BYTES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_TF, S_POLL, S_XFER, S_BSY, S_ALT, S_STAT
  } sst_e;

  sst_e          st;
  logic [2:0]    idx;
  logic          is_wr;
  logic [27:0]   lba_q;
  logic [7:0]    cnt_q;
  logic [7:0]    sec_left;
  logic [BW-1:0] byte_cnt;
  logic          pend;
  logic [7:0]    tf_byte;
  logic          ready_seen;

  assign req_ready  = (st == S_IDLE);
  assign wr_ready   = (st == S_XFER) && is_wr && !pend;
  assign tmr_run    = (st == S_POLL) || (st == S_BSY);
  assign ready_seen = !eng_rdata[BIT_BSY] && eng_rdata[BIT_DRQ];

  always_comb begin
    unique case (idx)
      3'd0:    tf_byte = cnt_q;
      3'd1:    tf_byte = lba_q[7:0];
      3'd2:    tf_byte = lba_q[15:8];
      3'd3:    tf_byte = lba_q[23:16];
      3'd4:    tf_byte = {4'hE, lba_q[27:24]};
      default: tf_byte = is_wr ? CMD_WR_SECT : CMD_RD_SECT;
    endcase
  end

  always_comb begin
    eng_start = 1'b0;
    eng_op    = '0;
    unique case (st)
      S_TF: begin
        eng_start    = !pend;
        eng_op.wr    = 1'b1;
        eng_op.addr  = 3'(idx + RA_CNT);
        eng_op.wdata = tf_byte;
      end
      S_POLL, S_BSY, S_STAT: begin
        eng_start   = !pend;
        eng_op.addr = RA_STAT;
      end
      S_ALT: begin
        eng_start   = !pend && !rd_valid;
        eng_op.alt  = 1'b1;
        eng_op.addr = RA_ALT;
      end
      S_XFER: begin
        eng_op.addr = RA_DATA;
        if (is_wr) begin
          eng_start    = !pend && wr_valid;
          eng_op.wr    = 1'b1;
          eng_op.wdata = wr_data;
        end else begin
          eng_start = !pend && !rd_valid;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      idx         <= '0;
      is_wr       <= 1'b0;
      lba_q       <= '0;
      cnt_q       <= '0;
      sec_left    <= '0;
      byte_cnt    <= '0;
      pend        <= 1'b0;
      xfer_done   <= 1'b0;
      xfer_status <= XS_OK;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (eng_start)     pend <= 1'b1;
      else if (eng_done) pend <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;

      unique case (st)
        S_IDLE: if (req_valid) begin
          if (req_count == 8'd0) begin
            xfer_done   <= 1'b1;
            xfer_status <= XS_PARAM;
          end else if (!card_ready) begin
            xfer_done   <= 1'b1;
            xfer_status <= XS_NOTRDY;
          end else begin
            is_wr    <= req_write;
            lba_q    <= req_lba;
            cnt_q    <= req_count;
            sec_left <= req_count;
            idx      <= '0;
            st       <= S_TF;
          end
        end
        S_TF: if (eng_done) begin
          if (idx == 3'd5) st <= S_POLL;
          else             idx <= idx + 1'b1;
        end
        S_POLL: if (eng_done) begin
          if (ready_seen) begin
            st       <= S_XFER;
            byte_cnt <= '0;
          end else if (tmr_expired) begin
            st          <= S_IDLE;
            xfer_done   <= 1'b1;
            xfer_status <= XS_TIMEOUT;
          end
        end
        S_XFER: if (eng_done) begin
          if (!is_wr) begin
            rd_valid <= 1'b1;
            rd_data  <= eng_rdata;
          end
          if (byte_cnt == LAST_BYTE) begin
            byte_cnt <= '0;
            sec_left <= sec_left - 1'b1;
            if (sec_left == 8'd1) st <= is_wr ? S_BSY : S_ALT;
            else                  st <= S_POLL;
          end else begin
            byte_cnt <= byte_cnt + 1'b1;
          end
        end
        S_BSY: if (eng_done) begin
          if (!eng_rdata[BIT_BSY]) begin
            if (eng_rdata[BIT_ERR]) begin
              st          <= S_IDLE;
              xfer_done   <= 1'b1;
              xfer_status <= XS_DEVERR;
            end else begin
              st <= S_ALT;
            end
          end else if (tmr_expired) begin
            st          <= S_IDLE;
            xfer_done   <= 1'b1;
            xfer_status <= XS_TIMEOUT;
          end
        end
        S_ALT: if (eng_done) st <= S_STAT;
        S_STAT: if (eng_done) begin
          st          <= S_IDLE;
          xfer_done   <= 1'b1;
          xfer_status <= XS_OK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_no_read_while_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && eng_start) |-> (eng_op.wr || eng_op.addr != RA_DATA || eng_op.alt));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_busy_no_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_count != 8'd0 && card_ready) |=> !req_ready);

endmodule

// File: rtl/pio_sector_xfer.sv
module pio_sector_xfer
  import piox_pkg::*;
#(
  parameter int SETUP_CYC    = 2,
  parameter int STROBE_CYC   = 4,
  parameter int HOLD_CYC     = 2,
  parameter int TIMEOUT_CYC  = 125_000_000,
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        card_ready,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [27:0] req_lba,
  input  logic [7:0]  req_count,
  output logic        xfer_done,
  output logic [2:0]  xfer_status,
  input  logic [7:0]  wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [2:0]  ata_addr,
  output logic        ata_cs0_n,
  output logic        ata_cs1_n,
  output logic        ata_iord_n,
  output logic        ata_iowr_n,
  output logic [7:0]  ata_dout,
  output logic        ata_doe,
  input  logic [7:0]  ata_din
);
  logic       eng_start, eng_done;
  bus_op_t    eng_op;
  logic [7:0] eng_rdata;
  logic       tmr_run, tmr_expired;

  piox_seq #(.SECTOR_BYTES(SECTOR_BYTES)) u_seq (
    .clk, .rst_n, .card_ready,
    .req_valid, .req_ready, .req_write, .req_lba, .req_count,
    .xfer_done, .xfer_status,
    .wr_data, .wr_valid, .wr_ready,
    .rd_data, .rd_valid, .rd_ready,
    .eng_start, .eng_op, .eng_done, .eng_rdata,
    .tmr_run, .tmr_expired
  );

  piox_bus_engine #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_eng (
    .clk, .rst_n,
    .start (eng_start),
    .op    (eng_op),
    .done  (eng_done),
    .rdata (eng_rdata),
    .addr  (ata_addr),
    .cs0_n (ata_cs0_n),
    .cs1_n (ata_cs1_n),
    .iord_n(ata_iord_n),
    .iowr_n(ata_iowr_n),
    .dout  (ata_dout),
    .doe   (ata_doe),
    .din   (ata_din)
  );

  piox_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk, .rst_n,
    .run    (tmr_run),
    .expired(tmr_expired)
  );

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_iord_n || !ata_iowr_n) |=> ((ata_iord_n && ata_iowr_n) || $stable(ata_addr)));

  assert_one_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_cs0_n || ata_cs1_n));

  assert_doe_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ata_doe |-> (ata_iord_n && !(ata_cs0_n && ata_cs1_n)));

endmodule

// File: tb/sim_pio_sector_xfer.sv
`timescale 1ns/1ps
module sim_pio_sector_xfer;
  localparam int P_SETUP = 2, P_STROBE = 3, P_HOLD = 1, P_TMO = 3000, P_SEC = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic card_ready = 1'b1, req_valid = 1'b0, req_write = 1'b0;
  logic [27:0] req_lba = '0;
  logic [7:0]  req_count = '0;
  logic req_ready, xfer_done, wr_ready, rd_valid;
  logic [2:0] xfer_status;
  logic [7:0] wr_data = '0, rd_data;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [2:0] ata_addr;
  logic ata_cs0_n, ata_cs1_n, ata_iord_n, ata_iowr_n, ata_doe;
  logic [7:0] ata_dout, ata_din, dev_status;

  always #4 clk = ~clk;

  pio_sector_xfer #(.SETUP_CYC(P_SETUP), .STROBE_CYC(P_STROBE), .HOLD_CYC(P_HOLD),
    .TIMEOUT_CYC(P_TMO), .SECTOR_BYTES(P_SEC)) u0 (.*);

  int n_tests = 0, n_fail = 0, cyc = 0;

  function automatic logic [7:0] rdpat(int k); return 8'((k * 7) + (k >> 9)); endfunction
  function automatic logic [7:0] wgen(int k);  return 8'((k * 5 + 3) ^ (k >> 8)); endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int busy_left = 0, busy_reload = 0, dev_cnt = 0, byte_k = 0, sec_done = 0;
  bit drq_on = 0, dev_err = 0, never_ready = 0;
  int rd_k = 0, wr_k = 0, wr_bad = 0, stat_reads = 0, strobes = 0, doe_viol = 0;
  int tf_n = 0;
  int tf_addr [8];
  int tf_data [8];
  int tf_cs [8];
  logic [4:0] hist0 = '0, hist1 = '0;
  logic prev_rd = 1'b1, prev_wr = 1'b1;
  int low_run = 0, low_min = 1000, low_max = 0;
  int pre_run = 0, pre_min = 1000, pre_max = 0;
  int post_run = 0, post_min = 1000, post_max = 0;
  bit seen = 0;

  assign dev_status = (never_ready || busy_left > 0) ? 8'h80 :
                      drq_on ? 8'h58 : (dev_err ? 8'h51 : 8'h50);
  assign ata_din = (!ata_cs0_n && ata_addr == 3'd0) ? rdpat(rd_k) : dev_status;

  task automatic dev_adv();
    byte_k++;
    if (byte_k == P_SEC) begin
      byte_k = 0;
      sec_done++;
      if (sec_done == dev_cnt) drq_on = 0;
      busy_left = busy_reload;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!ata_iord_n || !ata_iowr_n) low_run++;
    else if (low_run > 0) begin
      if (low_run < low_min) low_min = low_run;
      if (low_run > low_max) low_max = low_run;
      low_run = 0;
    end
    if (ata_cs0_n && ata_cs1_n) begin
      if (seen) begin
        if (post_run < post_min) post_min = post_run;
        if (post_run > post_max) post_max = post_run;
      end
      post_run = 0; pre_run = 0; seen = 0;
    end else if (ata_iord_n && ata_iowr_n) begin
      if (!seen) pre_run++; else post_run++;
    end else if (!seen) begin
      seen = 1;
      if (pre_run < pre_min) pre_min = pre_run;
      if (pre_run > pre_max) pre_max = pre_run;
    end
    if (ata_doe && (!ata_iord_n || (ata_cs0_n && ata_cs1_n))) doe_viol++;
    if (!prev_rd && ata_iord_n) begin
      strobes++;
      hist1 = hist0;
      hist0 = {ata_cs0_n, ata_cs1_n, ata_addr};
      if (!ata_cs0_n && ata_addr == 3'd0) begin rd_k++; dev_adv(); end
      if (!ata_cs0_n && ata_addr == 3'd7) begin
        stat_reads++;
        if (busy_left > 0) busy_left--;
      end
    end
    if (!prev_wr && ata_iowr_n) begin
      strobes++;
      if (!ata_cs0_n && ata_addr == 3'd0) begin
        if (ata_dout !== wgen(wr_k)) wr_bad++;
        wr_k++;
        dev_adv();
      end else begin
        if (tf_n < 8) begin
          tf_addr[tf_n] = int'(ata_addr);
          tf_data[tf_n] = int'(ata_dout);
          tf_cs[tf_n]   = int'({ata_cs0_n, ata_cs1_n});
        end
        tf_n++;
        if (ata_addr == 3'd2) dev_cnt = int'(ata_dout);
        if (ata_addr == 3'd7) begin
          busy_left = busy_reload; drq_on = 1; byte_k = 0; sec_done = 0;
        end
      end
    end
    prev_rd = ata_iord_n;
    prev_wr = ata_iowr_n;
  end

  // ---------------- host streams ----------------
  bit rx_stall = 0, tx_gap = 0, tx_fired = 0;
  int rx_cnt = 0, rx_bad = 0, tx_cnt = 0, tx_total = 0;

  always @(negedge clk) begin
    rd_ready = rx_stall ? (cyc % 4 == 0) : 1'b1;
    if (rd_valid && rd_ready) begin
      if (rd_data !== rdpat(rx_cnt)) rx_bad++;
      rx_cnt++;
    end
    if (tx_fired) tx_cnt++;
    wr_data  = wgen(tx_cnt);
    wr_valid = (tx_cnt < tx_total) && (!tx_gap || (cyc % 3 != 0));
    tx_fired = wr_valid && wr_ready;
  end

  task automatic dev_clear(input int reload);
    busy_reload = reload; busy_left = 0; drq_on = 0; dev_err = 0; never_ready = 0;
    byte_k = 0; sec_done = 0; rd_k = 0; wr_k = 0; wr_bad = 0; stat_reads = 0;
    strobes = 0; tf_n = 0; rx_cnt = 0; rx_bad = 0; tx_cnt = 0; tx_total = 0;
    rx_stall = 0; tx_gap = 0;
  endtask

  task automatic issue(input bit w, input logic [27:0] lba, input logic [7:0] n,
                       output int st, output int rdy_after, output int cycles);
    @(negedge clk);
    req_write = w; req_lba = lba; req_count = n; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_after = int'(req_ready);
    cycles = 1;
    while (!xfer_done) begin @(negedge clk); cycles++; end
    st = int'(xfer_status);
    @(negedge clk);
    chk("R13 done pulse width", int'(xfer_done), 0);
  endtask

  task automatic check_tf(input string tag, input logic [27:0] lba, input int n, input int cmd);
    chk({tag, " R4 task-file write count"}, tf_n, 6);
    for (int i = 0; i < 6; i++) begin
      int exp;
      case (i)
        0: exp = n;
        1: exp = int'(lba[7:0]);
        2: exp = int'(lba[15:8]);
        3: exp = int'(lba[23:16]);
        4: exp = int'({4'hE, lba[27:24]});
        default: exp = cmd;
      endcase
      chk({tag, " R4 task-file address"}, tf_addr[i], i + 2);
      chk({tag, " R4 task-file data"}, tf_data[i], exp);
      chk({tag, " R4 task-file chip selects"}, tf_cs[i], 1);
    end
  endtask

  task automatic check_timing();
    chk("R5 strobe low min", low_min, P_STROBE);
    chk("R5 strobe low max", low_max, P_STROBE);
    chk("R5 setup min", pre_min, P_SETUP);
    chk("R5 setup max", pre_max, P_SETUP);
    chk("R5 hold min", post_min, P_HOLD);
    chk("R5 hold max", post_max, P_HOLD);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 iord_n", int'(ata_iord_n), 1);
    chk("R1 iowr_n", int'(ata_iowr_n), 1);
    chk("R1 chip selects", int'({ata_cs0_n, ata_cs1_n}), 3);
    chk("R1 doe", int'(ata_doe), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 done and rd_valid", int'({xfer_done, rd_valid}), 0);
  endtask

  task automatic t_param();
    int st, ra, c;
    dev_clear(0);
    issue(1'b0, 28'h123, 8'd0, st, ra, c);
    chk("R2 zero count status", st, 3);
    chk("R2 no bus access", strobes, 0);
  endtask

  task automatic t_notready();
    int st, ra, c;
    dev_clear(0);
    card_ready = 1'b0;
    issue(1'b1, 28'h456, 8'd2, st, ra, c);
    card_ready = 1'b1;
    chk("R3 not ready status", st, 4);
    chk("R3 no bus access", strobes, 0);
  endtask

  task automatic t_read1();
    int st, ra, c;
    dev_clear(3);
    issue(1'b0, 28'h9A5C3E1, 8'd1, st, ra, c);
    repeat (4) @(negedge clk);
    chk("R13 req_ready low while busy", ra, 0);
    check_tf("read1", 28'h9A5C3E1, 1, 8'h20);
    chk("R11 read1 status ok", st, 0);
    chk("R8 read1 byte count", rx_cnt, P_SEC);
    chk("R8 read1 data mismatches", rx_bad, 0);
    chk("R6 read1 status reads (4 poll + 1 final)", stat_reads, 5);
    chk("R11 alt status read second to last", int'(hist1), int'(5'b10110));
    chk("R11 status read last", int'(hist0), int'(5'b01111));
    check_timing();
  endtask

  task automatic t_read2_stall();
    int st, ra, c;
    dev_clear(1);
    rx_stall = 1;
    issue(1'b0, 28'h0000010, 8'd2, st, ra, c);
    repeat (8) @(negedge clk);
    chk("R12 read2 status ok", st, 0);
    chk("R12 read2 byte count", rx_cnt, 2 * P_SEC);
    chk("R8 read2 stalled data mismatches", rx_bad, 0);
    chk("R8 device strobes equal bytes taken", rd_k, rx_cnt);
    chk("R6 read2 status reads (2+2+1)", stat_reads, 5);
  endtask

  task automatic t_write2();
    int st, ra, c;
    dev_clear(2);
    tx_gap = 1; tx_total = 2 * P_SEC;
    issue(1'b1, 28'h7FEDCBA, 8'd2, st, ra, c);
    check_tf("write2", 28'h7FEDCBA, 2, 8'h30);
    chk("R12 write2 status ok", st, 0);
    chk("R9 write2 bytes on bus", wr_k, 2 * P_SEC);
    chk("R9 write2 data mismatches", wr_bad, 0);
    chk("R9 write2 doe outside write access", doe_viol, 0);
    chk("R9 doe low after sector", int'(ata_doe), 0);
    chk("R10 write2 status reads (3+3+3+1)", stat_reads, 10);
    chk("R11 write2 alt then status", int'({hist1, hist0}), int'({5'b10110, 5'b01111}));
    check_timing();
  endtask

  task automatic t_write_err();
    int st, ra, c;
    dev_clear(1);
    dev_err = 1; tx_total = P_SEC;
    issue(1'b1, 28'h0000001, 8'd1, st, ra, c);
    chk("R10 device error status", st, 1);
    chk("R9 write_err bytes on bus", wr_k, P_SEC);
  endtask

  task automatic t_timeout();
    int st, ra, c;
    dev_clear(0);
    never_ready = 1;
    issue(1'b0, 28'h0000002, 8'd1, st, ra, c);
    chk("R7 timeout status", st, 2);
    chk("R7 waited at least the limit", int'(c >= P_TMO), 1);
    chk("R7 no data moved", rx_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_param();
    t_notready();
    t_read1();
    t_read2_stall();
    t_write2();
    t_write_err();
    t_timeout();
    chk("R13 idle after all", int'(req_ready), 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule